// File: doc/BRIEF.md
# Byte-Lane Steering Bus Bridge

This bridge sits between a 16-bit processor data bus and three classes of peripheral. The classes are 8-bit devices wired to the upper byte lane, 8-bit devices wired to the lower byte lane, and 16-bit devices. For each bus cycle the processor presents a start pulse, a data-strobe-active flag, a word/byte flag, address bit 0, a direction and a one-hot class select. The bridge builds the 16-bit value the selected peripheral sees, filling every undriven lane with ones. It issues a single-cycle read or write strobe to that peripheral only. It then returns the read data on the lane the processor strobed, replicated on both halves of the return bus.

The upper-lane class holds a group of identical serial controllers that share one address window. Consecutive blocks of `SER_REGS` register addresses select successive controllers. A cycle with no active data strobe, or with no matching select, touches no peripheral and is acknowledged after one clock.

The controller has three states. `ST_IDLE` waits for a cycle start. On a start it takes the transition *access* to `ST_STROBE` when a data strobe is active and a class matches, and otherwise the transition *skip* to `ST_RESPOND`. `ST_STROBE` drives the peripheral strobe and always takes the transition *capture* to `ST_RESPOND`, where the read data is registered. `ST_RESPOND` drives the acknowledge and takes the transition *finish* back to `ST_IDLE`.

Top module: `bus_lane_bridge`

## Requirements
- R1: On a word access (`cpu_word`=1) the 16-bit data passes unchanged: the write value reaches `wd_wdata` as-is, and the 16-bit read value returns as-is on `cpu_rdata`.
- R2: On a byte write the processor's byte is taken from `cpu_wdata[7:0]` and placed on bits 15:8 when `cpu_a0`=0, or on bits 7:0 when `cpu_a0`=1. The other lane is presented as 0xFF.
- R3: On a byte read the returned byte is bits 15:8 of the peripheral's 16-bit value when `cpu_a0`=0, and bits 7:0 when `cpu_a0`=1.
- R4: An upper-lane peripheral (select bit 0) reads as {data, 0xFF} and is written with bits 15:8 of the lane value, so a byte write at an odd address delivers 0xFF.
- R5: A lower-lane peripheral (select bit 1) reads as {0xFF, data} and is written with bits 7:0 of the lane value, so a byte write at an even address delivers 0xFF.
- R6: A cycle with `cpu_ds`=0, or with no class select (bits 0/1/2 = upper/lower/wide), issues no strobe. It is acknowledged on the next clock with `cpu_rdata`=0xFFFF.
- R7: A 16-bit peripheral read returns a 1 in every bit where `wd_rmask` is 0.
- R8: Within the upper-lane window, controller k is selected by register addresses k*SER_REGS through k*SER_REGS+SER_REGS-1. Its byte is read from `ser_rdata[8k+7:8k]`.
- R9: Each strobe is a single-cycle pulse, at most one strobe is active at a time, and only the addressed peripheral receives it.
- R10: `cpu_ack` is a one-cycle pulse in the clock after the strobe, with the registered read data on `cpu_rdata`. A write returns 0xFFFF.
- R11: A byte read presents the returned byte on both halves of `cpu_rdata`.
- R12: After reset, no strobe and no acknowledge are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Cycle start pulse, sampled in idle |
| cpu_ds | input | 1 | At least one data strobe active |
| cpu_word | input | 1 | 1 = word access, 0 = byte access |
| cpu_a0 | input | 1 | Address bit 0 (byte parity) |
| cpu_rd | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | ADDR_W | Peripheral register address |
| cpu_sel | input | 3 | One-hot class select: bit0 upper lane, bit1 lower lane, bit2 wide |
| cpu_wdata | input | 16 | Processor write data (byte writes in bits 7:0) |
| cpu_rdata | output | 16 | Registered read data |
| cpu_ack | output | 1 | Cycle acknowledge pulse |
| per_addr | output | ADDR_W | Latched register address to peripherals |
| ser_rd | output | NUM_SER | Read strobes, upper-lane controllers |
| ser_wr | output | NUM_SER | Write strobes, upper-lane controllers |
| ser_wdata | output | 8 | Write byte to upper-lane controllers |
| ser_rdata | input | NUM_SER*8 | Read bytes from upper-lane controllers |
| lo_rd | output | 1 | Read strobe, lower-lane peripheral |
| lo_wr | output | 1 | Write strobe, lower-lane peripheral |
| lo_wdata | output | 8 | Write byte to lower-lane peripheral |
| lo_rdata | input | 8 | Read byte from lower-lane peripheral |
| wd_rd | output | 1 | Read strobe, 16-bit peripheral |
| wd_wr | output | 1 | Write strobe, 16-bit peripheral |
| wd_wdata | output | 16 | Write word to 16-bit peripheral |
| wd_rdata | input | 16 | Read word from 16-bit peripheral |
| wd_rmask | input | 16 | Meaningful-bit mask of the 16-bit read word |

## Verification
The bench targets byte accesses that land on the lane a peripheral is not wired to: odd-address writes to the upper-lane device, even-address writes to the lower-lane device, and the mirrored reads. A bridge that steered by the peripheral instead of by parity would deliver the processor's byte there instead of 0xFF. It also covers the window boundary between the two serial controllers, where an off-by-one in the split would strobe the wrong controller. Two further cases are a masked 16-bit read, where a missing fill would return zeros in unused bits, and a strobe-less cycle, where a bridge that still accessed a device would pulse a strobe or stall the acknowledge.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_RESPOND
    } bridge_state_t;

    typedef enum logic [1:0] {
        CLS_NONE,
        CLS_HI,
        CLS_LO,
        CLS_WIDE
    } lane_cls_t;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;

endpackage

// File: rtl/bridge_fsm.sv
module bridge_fsm
    import bridge_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          go_access,
    output bridge_state_t state
);

    bridge_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_d = go_access ? ST_STROBE : ST_RESPOND;
                end
            end
            ST_STROBE:  state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/lane_pack.sv
module lane_pack
    import bridge_pkg::*;
(
    input  logic             word,
    input  logic             a0,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] lanes
);

    localparam logic [BYTE_W-1:0] FILL = '1;

    always_comb begin
        if (word) begin
            lanes = wdata;
        end else if (a0) begin
            lanes = {FILL, wdata[BYTE_W-1:0]};
        end else begin
            lanes = {wdata[BYTE_W-1:0], FILL};
        end
    end

endmodule

// File: rtl/lane_merge.sv
module lane_merge
    import bridge_pkg::*;
(
    input  lane_cls_t         cls,
    input  logic              word,
    input  logic              a0,
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [BYTE_W-1:0] lo_byte,
    input  logic [BUS_W-1:0]  wide_data,
    input  logic [BUS_W-1:0]  wide_mask,
    output logic [BUS_W-1:0]  ret
);

    localparam logic [BYTE_W-1:0] FILL = '1;

    logic [BUS_W-1:0]  periph;
    logic [BYTE_W-1:0] pick;

    always_comb begin
        unique case (cls)
            CLS_HI:   periph = {hi_byte, FILL};
            CLS_LO:   periph = {FILL, lo_byte};
            CLS_WIDE: periph = wide_data | ~wide_mask;
            default:  periph = '1;
        endcase
        pick = a0 ? periph[BYTE_W-1:0] : periph[BUS_W-1:BYTE_W];
        ret  = word ? periph : {pick, pick};
    end

endmodule

// File: rtl/bus_lane_bridge.sv
module bus_lane_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_SER  = 2,
    parameter int SER_REGS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_ds,
    input  logic                      cpu_word,
    input  logic                      cpu_a0,
    input  logic                      cpu_rd,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [2:0]                cpu_sel,
    input  logic [15:0]               cpu_wdata,
    output logic [15:0]               cpu_rdata,
    output logic                      cpu_ack,
    output logic [ADDR_W-1:0]         per_addr,
    output logic [NUM_SER-1:0]        ser_rd,
    output logic [NUM_SER-1:0]        ser_wr,
    output logic [7:0]                ser_wdata,
    input  logic [NUM_SER*8-1:0]      ser_rdata,
    output logic                      lo_rd,
    output logic                      lo_wr,
    output logic [7:0]                lo_wdata,
    input  logic [7:0]                lo_rdata,
    output logic                      wd_rd,
    output logic                      wd_wr,
    output logic [15:0]               wd_wdata,
    input  logic [15:0]               wd_rdata,
    input  logic [15:0]               wd_rmask
);

    localparam int SER_SH    = $clog2(SER_REGS);
    localparam int SER_IDX_W = (NUM_SER > 1) ? $clog2(NUM_SER) : 1;

    bridge_state_t           state_q;
    lane_cls_t               cls_now;
    lane_cls_t               lat_cls;
    logic [ADDR_W-1:0]       ser_idx_full;
    logic                    ser_hit;
    logic [SER_IDX_W-1:0]    lat_ser;
    logic                    lat_word;
    logic                    lat_a0;
    logic                    lat_rd;
    logic [ADDR_W-1:0]       lat_addr;
    logic [BUS_W-1:0]        lat_wdata;
    logic [BUS_W-1:0]        lanes;
    logic [BUS_W-1:0]        merged;
    logic [BYTE_W-1:0]       ser_byte;
    logic                    in_strobe;
    logic                    go_access;
    logic                    take;

    // Class decode for the cycle being started
    always_comb begin
        ser_idx_full = cpu_addr >> SER_SH;
        ser_hit      = ser_idx_full < ADDR_W'(NUM_SER);
        if (cpu_sel[0] && ser_hit) begin
            cls_now = CLS_HI;
        end else if (cpu_sel[1]) begin
            cls_now = CLS_LO;
        end else if (cpu_sel[2]) begin
            cls_now = CLS_WIDE;
        end else begin
            cls_now = CLS_NONE;
        end
    end

    assign go_access = cpu_ds && (cls_now != CLS_NONE);
    assign take      = (state_q == ST_IDLE) && cpu_req;

    bridge_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cpu_req),
        .go_access (go_access),
        .state     (state_q)
    );

    // Cycle capture and registered read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_cls   <= CLS_NONE;
            lat_ser   <= '0;
            lat_word  <= 1'b0;
            lat_a0    <= 1'b0;
            lat_rd    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '1;
            cpu_rdata <= '1;
        end else if (take) begin
            lat_cls   <= go_access ? cls_now : CLS_NONE;
            lat_ser   <= ser_idx_full[SER_IDX_W-1:0];
            lat_word  <= cpu_word;
            lat_a0    <= cpu_a0;
            lat_rd    <= cpu_rd;
            lat_addr  <= cpu_addr;
            lat_wdata <= cpu_wdata;
            cpu_rdata <= '1;
        end else if (state_q == ST_STROBE && lat_rd) begin
            cpu_rdata <= merged;
        end
    end

    lane_pack u_pack (
        .word  (lat_word),
        .a0    (lat_a0),
        .wdata (lat_wdata),
        .lanes (lanes)
    );

    always_comb begin
        ser_byte = '1;
        for (int i = 0; i < NUM_SER; i++) begin
            if (lat_ser == SER_IDX_W'(i)) begin
                ser_byte = ser_rdata[i*BYTE_W +: BYTE_W];
            end
        end
    end

    lane_merge u_merge (
        .cls       (lat_cls),
        .word      (lat_word),
        .a0        (lat_a0),
        .hi_byte   (ser_byte),
        .lo_byte   (lo_rdata),
        .wide_data (wd_rdata),
        .wide_mask (wd_rmask),
        .ret       (merged)
    );

    // Outputs decoded from the state register
    assign in_strobe = (state_q == ST_STROBE);
    assign cpu_ack   = (state_q == ST_RESPOND);
    assign per_addr  = lat_addr;
    assign ser_wdata = lanes[BUS_W-1:BYTE_W];
    assign lo_wdata  = lanes[BYTE_W-1:0];
    assign wd_wdata  = lanes;

    generate
        for (genvar g = 0; g < NUM_SER; g++) begin : g_ser
            logic hit_g;
            assign hit_g     = in_strobe && (lat_cls == CLS_HI) && (lat_ser == SER_IDX_W'(g));
            assign ser_rd[g] = hit_g && lat_rd;
            assign ser_wr[g] = hit_g && !lat_rd;
        end
    endgenerate

    assign lo_rd = in_strobe && (lat_cls == CLS_LO) && lat_rd;
    assign lo_wr = in_strobe && (lat_cls == CLS_LO) && !lat_rd;
    assign wd_rd = in_strobe && (lat_cls == CLS_WIDE) && lat_rd;
    assign wd_wr = in_strobe && (lat_cls == CLS_WIDE) && !lat_rd;

endmodule

// File: rtl/bridge_chk.sv
module bridge_chk
    import bridge_pkg::*;
#(
    parameter int STB_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_req,
    input logic             cpu_ds,
    input logic             cpu_ack,
    input logic [15:0]      cpu_rdata,
    input logic [STB_W-1:0] stb,
    input bridge_state_t    state,
    input logic             lat_word,
    input logic             lat_rd
);

    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb));

    assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb != '0) |=> (stb == '0));

    assert_ack_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stb != '0) |=> cpu_ack);

    assert_ack_not_with_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stb != '0) |-> !cpu_ack);

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    assert_skip_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cpu_req && !cpu_ds) |=>
            (cpu_ack && stb == '0 && cpu_rdata == 16'hFFFF));

    assert_byte_mirror_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && lat_rd && !lat_word) |-> (cpu_rdata[15:8] == cpu_rdata[7:0]));

endmodule

bind bus_lane_bridge bridge_chk #(.STB_W(4 + 2*NUM_SER)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ds    (cpu_ds),
    .cpu_ack   (cpu_ack),
    .cpu_rdata (cpu_rdata),
    .stb       ({wd_wr, wd_rd, lo_wr, lo_rd, ser_wr, ser_rd}),
    .state     (state_q),
    .lat_word  (lat_word),
    .lat_rd    (lat_rd)
);

// File: tb/bus_lane_bridge_bench.sv
module bus_lane_bridge_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_ds = 1'b0, cpu_word = 1'b0, cpu_a0 = 1'b0, cpu_rd = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [2:0]  cpu_sel = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ack;
    logic [3:0]  per_addr;
    logic [1:0]  ser_rd, ser_wr;
    logic [7:0]  ser_wdata;
    logic [15:0] ser_rdata = 16'hB2A1;
    logic        lo_rd, lo_wr;
    logic [7:0]  lo_wdata;
    logic [7:0]  lo_rdata = 8'h3C;
    logic        wd_rd, wd_wr;
    logic [15:0] wd_wdata;
    logic [15:0] wd_rdata = 16'h5A96;
    logic [15:0] wd_rmask = 16'hFFFF;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    bus_lane_bridge u_bus_lane_bridge (.*);

    // {sel, addr, word, a0, rd, wdata, expected, strobe}
    // strobe bits: {wd_wr, wd_rd, lo_wr, lo_rd, ser_wr[1:0], ser_rd[1:0]}
    localparam logic [49:0] VEC [18] = '{
        {3'b100, 4'd0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'h5A96, 8'h40},
        {3'b100, 4'd0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h5A5A, 8'h40},
        {3'b100, 4'd0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h9696, 8'h40},
        {3'b001, 4'd0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'hA1FF, 8'h01},
        {3'b001, 4'd2, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hB2B2, 8'h02},
        {3'b001, 4'd1, 1'b0, 1'b1, 1'b1, 16'h0000, 16'hFFFF, 8'h01},
        {3'b010, 4'd0, 1'b1, 1'b0, 1'b1, 16'h0000, 16'hFF3C, 8'h10},
        {3'b010, 4'd0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h3C3C, 8'h10},
        {3'b010, 4'd0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 8'h10},
        {3'b100, 4'd0, 1'b1, 1'b0, 1'b0, 16'h1234, 16'h1234, 8'h80},
        {3'b100, 4'd0, 1'b0, 1'b0, 1'b0, 16'h00C7, 16'hC7FF, 8'h80},
        {3'b100, 4'd0, 1'b0, 1'b1, 1'b0, 16'h00C7, 16'hFFC7, 8'h80},
        {3'b001, 4'd3, 1'b0, 1'b0, 1'b0, 16'h005E, 16'h005E, 8'h08},
        {3'b001, 4'd0, 1'b0, 1'b1, 1'b0, 16'h005E, 16'h00FF, 8'h04},
        {3'b001, 4'd0, 1'b1, 1'b0, 1'b0, 16'hABCD, 16'h00AB, 8'h04},
        {3'b010, 4'd0, 1'b1, 1'b0, 1'b0, 16'hABCD, 16'h00CD, 8'h20},
        {3'b010, 4'd0, 1'b0, 1'b1, 1'b0, 16'h0077, 16'h0077, 8'h20},
        {3'b010, 4'd0, 1'b0, 1'b0, 1'b0, 16'h0077, 16'h00FF, 8'h20}
    };

    function automatic logic [7:0] strobes();
        return {wd_wr, wd_rd, lo_wr, lo_rd, ser_wr, ser_rd};
    endfunction

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Start a cycle at a falling edge; return strobes seen and read data at ack
    task automatic run_cycle(input logic [2:0] sel, input logic [3:0] addr, input logic ds,
                             input logic word, input logic a0, input logic rd,
                             input logic [15:0] wdata,
                             output logic [7:0] stb_seen, output logic [15:0] wseen,
                             output logic [15:0] rseen, output logic ack_early,
                             output logic ack_seen);
        cpu_sel = sel; cpu_addr = addr; cpu_ds = ds; cpu_word = word;
        cpu_a0 = a0; cpu_rd = rd; cpu_wdata = wdata; cpu_req = 1'b1;
        @(negedge clk);
        cpu_req   = 1'b0;
        stb_seen  = strobes();
        ack_early = cpu_ack;
        if (sel == 3'b100)      wseen = wd_wdata;
        else if (sel == 3'b010) wseen = {8'h00, lo_wdata};
        else                    wseen = {8'h00, ser_wdata};
        if (!ack_early) @(negedge clk);
        ack_seen = cpu_ack;
        rseen    = cpu_rdata;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0]  stb;
        logic [15:0] wv, rv;
        logic        early, ack;
        string       tag;

        repeat (3) @(negedge clk);
        // R12: reset state
        check(strobes() == 8'h00 && !cpu_ack, "R12 reset quiet", {7'b0, cpu_ack, strobes()}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VEC[i]) begin
            logic [2:0]  s  = VEC[i][49:47];
            logic [3:0]  ad = VEC[i][46:43];
            logic        w  = VEC[i][42];
            logic        a  = VEC[i][41];
            logic        r  = VEC[i][40];
            logic [15:0] wd = VEC[i][39:24];
            logic [15:0] ex = VEC[i][23:8];
            logic [7:0]  es = VEC[i][7:0];
            run_cycle(s, ad, 1'b1, w, a, r, wd, stb, wv, rv, early, ack);
            if (w && s == 3'b100)      tag = "R1";
            else if (s == 3'b100)      tag = r ? "R3" : "R2";
            else if (s == 3'b001)      tag = (ad >= 4'd2) ? "R8" : "R4";
            else                       tag = "R5";
            check(stb == es, "R9 strobe select", {8'h00, stb}, {8'h00, es});
            check(!early && ack, "R10 ack timing", {14'b0, early, ack}, 16'h0001);
            if (r) begin
                check(rv == ex, tag, rv, ex);
                if (!w) check(rv[15:8] == rv[7:0], "R11 byte mirror", rv, {ex[7:0], ex[7:0]});
            end else begin
                check(wv == ex, tag, wv, ex);
                check(rv == 16'hFFFF, "R10 write return", rv, 16'hFFFF);
            end
        end

        // R6: no data strobe
        run_cycle(3'b100, 4'd0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, stb, wv, rv, early, ack);
        check(stb == 8'h00 && early, "R6 no strobe", {7'b0, early, stb}, 16'h0100);
        check(rv == 16'hFFFF, "R6 no strobe data", rv, 16'hFFFF);
        // R6: no class select
        run_cycle(3'b000, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, stb, wv, rv, early, ack);
        check(stb == 8'h00 && early, "R6 no select", {7'b0, early, stb}, 16'h0100);
        // R8: address beyond the serial window strobes nothing
        run_cycle(3'b001, 4'd4, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, stb, wv, rv, early, ack);
        check(stb == 8'h00, "R8 outside window", {8'h00, stb}, 16'h0000);
        // R7: masked wide read
        wd_rmask = 16'h0003;
        wd_rdata = 16'h0002;
        run_cycle(3'b100, 4'd0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000, stb, wv, rv, early, ack);
        check(rv == 16'hFFFE, "R7 word fill", rv, 16'hFFFE);
        run_cycle(3'b100, 4'd0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0000, stb, wv, rv, early, ack);
        check(rv == 16'hFEFE, "R7 byte fill", rv, 16'hFEFE);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule